// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator with Fast-Interrupt Routing

This block gathers 64 peripheral interrupt lines and 8 local interrupt lines, all level-sensitive, and reduces them to two outputs for a processor: a normal interrupt request and a fast interrupt request. Each input is sampled into a status flop on every clock. A set of enable masks gates the sampled levels into the normal request. The peripheral sources have their own 64-bit enable bank, and the local sources have their own 8-bit bank. The fast request ignores the masks. It follows the raw level of one source chosen by a 7-bit selector, and only while its own enable bit is set.

Software reaches the block through a simple 32-bit register port with a valid strobe, a write flag, a byte address and write data. Enables are never written directly. Each bank has a write-one-to-set address and a write-one-to-clear address, so separate drivers can change their own bits without a read-modify-write. A summary word gives the local pending bits, one flag for each nonempty peripheral half, and copies of eleven chosen peripheral sources. A handler can therefore often find the cause of an interrupt with a single read.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every enable bit, the fast enable and the fast selector are zero. Both interrupt outputs are low, and `reg_rvalid` is low while no read is requested.
- R2: A read of byte offset 0x04 returns the sampled levels of peripheral sources 0–31 ANDed with their enables, and offset 0x08 does the same for sources 32–63 (source 32 in bit 0).
- R3: A write to 0x10 (sources 0–31), 0x14 (sources 32–63) or 0x18 (local sources, data bits 7:0 only) sets each enable bit whose data bit is one and leaves every other enable bit as it was.
- R4: A write to 0x1C, 0x20 or 0x24 clears each enable bit of the matching bank (same slicing as R3) whose data bit is one and leaves the rest as they were.
- R5: A read of a set address (0x10/0x14/0x18) returns the current enable bits, zero-extended for the local bank. A read of a clear address (0x1C/0x20/0x24) returns the 32-bit complement of that value, so the local clear address reads ones in bits 31:8.
- R6: A read of offset 0x00 returns the summary word. Bits 7:0 are local levels ANDed with local enables. Bit 8 is set if any enabled peripheral source 0–31 is active. Bit 9 is set if any enabled source 32–63 is active. Bits 10 to 20 hold the enabled-and-active state of peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62, in that order. Bits 31:21 are zero.
- R7: `irq_o` is high exactly when some source, peripheral or local, is both active and enabled.
- R8: Offset 0x0C holds the fast control: selector in bits 6:0 and fast enable in bit 7. Writes take data bits 7:0, and reads return them with bits 31:8 zero.
- R9: With the fast enable set, `fiq_o` equals the raw level of the selected source whatever the enable masks hold. Selector values 0–63 pick a peripheral source, and values 64–71 pick local source (selector − 64). With the fast enable clear, `fiq_o` is low.
- R10: Selector values 72–127 hold `fiq_o` low even with the fast enable set.
- R11: Reads of offsets with no register (0x28 and above) return zero. Writes to such offsets, or to 0x00, 0x04 or 0x08, change no enable bit and no fast-control bit.
- R12: Both outputs reflect a level change or a register write at the first rising clock edge after it. Read data and `reg_rvalid` appear at the first rising edge after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| periph_lvl | input | 64 | Peripheral interrupt levels, source n on bit n |
| local_lvl | input | 8 | Local interrupt levels, source n on bit n |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data strobe, one cycle after the request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The masking function is driven with a level pattern that lights only the mirrored peripheral sources under full enables. It is also driven with all levels high under only the upper-half enables, with a mixed hexadecimal level pattern, and with a local pattern under a partial local mask. Between them these patterns separate the two half flags and the eleven mirror positions from one another, and show any bit that leaks through a cleared mask. The fast path is tried with the selected source masked off and other sources idle, which shows that it bypasses the masks. It is also tried at a local selector value, at the out-of-range boundaries 72 and 127, and with its enable cleared. Output timing is checked one edge after a level change, with the output observed still low before that edge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int PERIPH_N  = 64;
  localparam int LOCAL_N   = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 9;
  localparam int SEL_W     = 7;
  localparam int MIRROR_N  = 11;
  localparam int MIRROR_LSB = 10;
  localparam int REG_WORDS = 10;
  localparam int WIDX_W    = ADDR_W - 2;

  // word index = byte offset / 4
  typedef enum logic [3:0] {
    W_SUMMARY = 4'd0,
    W_PEND_LO = 4'd1,
    W_PEND_HI = 4'd2,
    W_FAST    = 4'd3,
    W_PSET_LO = 4'd4,
    W_PSET_HI = 4'd5,
    W_LSET    = 4'd6,
    W_PCLR_LO = 4'd7,
    W_PCLR_HI = 4'd8,
    W_LCLR    = 4'd9
  } reg_word_e;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } fast_ctrl_t;

  // peripheral source copied into summary bit MIRROR_LSB + k
  function automatic int mirror_src(input int k);
    case (k)
      0:  return 7;
      1:  return 9;
      2:  return 10;
      3:  return 18;
      4:  return 19;
      5:  return 53;
      6:  return 54;
      7:  return 55;
      8:  return 56;
      9:  return 57;
      default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/irqagg_mask_bank.sv
module irqagg_mask_bank #(
  parameter int WIDTH = 64,
  parameter int SLICE = 32,
  localparam int SLICES = WIDTH / SLICE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLICES-1:0] set_sel,
  input  logic [SLICES-1:0] clr_sel,
  input  logic [SLICE-1:0]  wdata,
  output logic [WIDTH-1:0]  en_q,
  output logic [WIDTH-1:0]  en_d
);

  logic bank_we;
  assign bank_we = |set_sel || |clr_sel;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int LO = s * SLICE;

    always_comb begin
      if (set_sel[s]) begin
        en_d[LO +: SLICE] = en_q[LO +: SLICE] | wdata;
      end else if (clr_sel[s]) begin
        en_d[LO +: SLICE] = en_q[LO +: SLICE] & ~wdata;
      end else begin
        en_d[LO +: SLICE] = en_q[LO +: SLICE];
      end
    end

    // R3: every written one ends up set in this slice
    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_sel[s] |=> ((en_q[LO +: SLICE] & $past(wdata)) == $past(wdata)));

    // R4: every written one ends up cleared in this slice
    p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sel[s] |=> ((en_q[LO +: SLICE] & $past(wdata)) == '0));

    // R3/R4: zero data bits leave the slice untouched
    p_zero_bits_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_sel[s] || clr_sel[s]) |=>
        ((en_q[LO +: SLICE] & ~$past(wdata)) == ($past(en_q[LO +: SLICE]) & ~$past(wdata))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (bank_we) begin
      en_q <= en_d;
    end
  end

  // R11: without a bank write the mask holds
  p_mask_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(en_q));

endmodule

// File: rtl/irqagg_fast_route.sv
module irqagg_fast_route
  import irqagg_pkg::*;
(
  input  fast_ctrl_t          ctrl,
  input  logic [PERIPH_N-1:0] periph_raw,
  input  logic [LOCAL_N-1:0]  local_raw,
  output logic                hit
);

  localparam int PI_W = $clog2(PERIPH_N);
  localparam int LI_W = $clog2(LOCAL_N);
  localparam logic [SEL_W-1:0] PERIPH_END = SEL_W'(PERIPH_N);
  localparam logic [SEL_W-1:0] LOCAL_END  = SEL_W'(PERIPH_N + LOCAL_N);

  logic [SEL_W-1:0] local_off;
  assign local_off = ctrl.sel - PERIPH_END;

  always_comb begin
    hit = 1'b0;
    if (ctrl.en) begin
      if (ctrl.sel < PERIPH_END) begin
        hit = periph_raw[ctrl.sel[PI_W-1:0]];
      end else if (ctrl.sel < LOCAL_END) begin
        hit = local_raw[local_off[LI_W-1:0]];
      end
    end
  end

endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary
  import irqagg_pkg::*;
(
  input  logic [PERIPH_N-1:0] periph_pend,
  input  logic [LOCAL_N-1:0]  local_pend,
  output logic [DATA_W-1:0]   word
);

  localparam int HALF = PERIPH_N / 2;
  localparam int TOP_LSB = MIRROR_LSB + MIRROR_N;

  assign word[LOCAL_N-1:0]    = local_pend;
  assign word[LOCAL_N]        = |periph_pend[HALF-1:0];
  assign word[LOCAL_N+1]      = |periph_pend[PERIPH_N-1:HALF];
  assign word[DATA_W-1:TOP_LSB] = '0;

  for (genvar k = 0; k < MIRROR_N; k++) begin : g_mirror
    localparam int SRC = mirror_src(k);
    assign word[MIRROR_LSB + k] = periph_pend[SRC];
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIPH_N-1:0] periph_lvl,
  input  logic [LOCAL_N-1:0]  local_lvl,
  input  logic                reg_valid,
  input  logic                reg_write,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_rvalid,
  output logic                irq_o,
  output logic                fiq_o
);

  localparam int PSLICES = PERIPH_N / DATA_W;
  localparam logic [SEL_W-1:0] LOCAL_END = SEL_W'(PERIPH_N + LOCAL_N);

  // ---------------- access decode ----------------
  logic              acc_wr, acc_rd, mapped;
  logic [WIDX_W-1:0] word_idx;
  reg_word_e         word;
  logic [REG_WORDS-1:0] wr_sel;
  logic              addr_lsb_unused;

  assign acc_wr   = reg_valid && reg_write;
  assign acc_rd   = reg_valid && !reg_write;
  assign word_idx = reg_addr[ADDR_W-1:2];
  assign mapped   = word_idx < WIDX_W'(REG_WORDS);
  assign word     = reg_word_e'(word_idx[3:0]);
  assign addr_lsb_unused = ^reg_addr[1:0];

  always_comb begin
    wr_sel = '0;
    if (acc_wr && mapped) begin
      wr_sel[word_idx[3:0]] = 1'b1;
    end
  end

  // ---------------- enable banks ----------------
  logic [PERIPH_N-1:0] pen_q, pen_d;
  logic [LOCAL_N-1:0]  len_q, len_d;

  irqagg_mask_bank #(.WIDTH(PERIPH_N), .SLICE(DATA_W)) u_periph_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_sel ({wr_sel[W_PSET_HI], wr_sel[W_PSET_LO]}),
    .clr_sel ({wr_sel[W_PCLR_HI], wr_sel[W_PCLR_LO]}),
    .wdata   (reg_wdata),
    .en_q    (pen_q),
    .en_d    (pen_d)
  );

  irqagg_mask_bank #(.WIDTH(LOCAL_N), .SLICE(LOCAL_N)) u_local_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_sel (wr_sel[W_LSET]),
    .clr_sel (wr_sel[W_LCLR]),
    .wdata   (reg_wdata[LOCAL_N-1:0]),
    .en_q    (len_q),
    .en_d    (len_d)
  );

  // ---------------- fast control ----------------
  fast_ctrl_t fast_q, fast_d;

  always_comb begin
    fast_d = fast_q;
    if (wr_sel[W_FAST]) begin
      fast_d = fast_ctrl_t'(reg_wdata[SEL_W:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0;
    end else if (wr_sel[W_FAST]) begin
      fast_q <= fast_d;
    end
  end

  // ---------------- level capture (no reset: tracks the pins) ----------------
  logic [PERIPH_N-1:0] plvl_q;
  logic [LOCAL_N-1:0]  llvl_q;

  always_ff @(posedge clk) begin
    plvl_q <= periph_lvl;
    llvl_q <= local_lvl;
  end

  // ---------------- outputs from next state ----------------
  logic irq_d, fiq_d;

  assign irq_d = (|(periph_lvl & pen_d)) || (|(local_lvl & len_d));

  irqagg_fast_route u_fast (
    .ctrl       (fast_d),
    .periph_raw (periph_lvl),
    .local_raw  (local_lvl),
    .hit        (fiq_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

  // ---------------- read path ----------------
  logic [PERIPH_N-1:0] ppend;
  logic [LOCAL_N-1:0]  lpend;
  logic [DATA_W-1:0]   summary, rdata_d;

  assign ppend = plvl_q & pen_q;
  assign lpend = llvl_q & len_q;

  irqagg_summary u_summary (
    .periph_pend (ppend),
    .local_pend  (lpend),
    .word        (summary)
  );

  always_comb begin
    rdata_d = '0;
    if (mapped) begin
      case (word)
        W_SUMMARY: rdata_d = summary;
        W_PEND_LO: rdata_d = ppend[DATA_W-1:0];
        W_PEND_HI: rdata_d = ppend[PSLICES*DATA_W-1:DATA_W];
        W_FAST:    rdata_d = DATA_W'(fast_q);
        W_PSET_LO: rdata_d = pen_q[DATA_W-1:0];
        W_PSET_HI: rdata_d = pen_q[PSLICES*DATA_W-1:DATA_W];
        W_LSET:    rdata_d = DATA_W'(len_q);
        W_PCLR_LO: rdata_d = ~pen_q[DATA_W-1:0];
        W_PCLR_HI: rdata_d = ~pen_q[PSLICES*DATA_W-1:DATA_W];
        W_LCLR:    rdata_d = ~DATA_W'(len_q);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= acc_rd;
      if (acc_rd) begin
        reg_rdata <= rdata_d;
      end
    end
  end

  // ---------------- assertions ----------------
  // R7: request agrees with the captured levels and masks
  p_irq_matches_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((|ppend) || (|lpend)));

  // R9: disabled fast path stays low
  p_fast_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_q.en |-> !fiq_o);

  // R9: peripheral selection follows the captured raw level
  p_fast_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q.en && fast_q.sel < SEL_W'(PERIPH_N)) |-> (fiq_o == plvl_q[fast_q.sel[5:0]]));

  // R9: local selection follows the captured raw level
  p_fast_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q.en && fast_q.sel >= SEL_W'(PERIPH_N) && fast_q.sel < LOCAL_END)
      |-> (fiq_o == llvl_q[fast_q.sel[2:0]]));

  // R10: out-of-range selector keeps the fast output low
  p_fast_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q.sel >= LOCAL_END) |-> !fiq_o);

  // R12: read strobe one edge after the request, and only then
  p_read_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> reg_rvalid);
  p_no_stray_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !reg_rvalid);

  // R11: unmapped reads give zero; unmapped writes leave fast control alone
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !mapped) |=> (reg_rdata == '0));
  p_fast_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[W_FAST] |=> $stable(fast_q));

endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

  localparam int MIR [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  logic        clk;
  logic        rst_n;
  logic [63:0] periph_lvl;
  logic [7:0]  local_lvl;
  logic        reg_valid, reg_write;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq_o, fiq_o;

  int n_checks = 0;
  int n_err    = 0;

  // bench model of software-visible state
  logic [63:0] m_pen;
  logic [7:0]  m_len;
  logic [7:0]  m_fast;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .periph_lvl(periph_lvl), .local_lvl(local_lvl),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_summary(input logic [63:0] pl, input logic [63:0] pe,
                                              input logic [7:0] ll, input logic [7:0] le);
    logic [63:0] p;
    logic [31:0] w;
    p = pl & pe;
    w = '0;
    w[7:0] = ll & le;
    w[8]   = |p[31:0];
    w[9]   = |p[63:32];
    for (int k = 0; k < 11; k++) w[10 + k] = p[MIR[k]];
    return w;
  endfunction

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    case (a)
      9'h0C: m_fast = d[7:0];
      9'h10: m_pen[31:0]  = m_pen[31:0]  | d;
      9'h14: m_pen[63:32] = m_pen[63:32] | d;
      9'h18: m_len        = m_len | d[7:0];
      9'h1C: m_pen[31:0]  = m_pen[31:0]  & ~d;
      9'h20: m_pen[63:32] = m_pen[63:32] & ~d;
      9'h24: m_len        = m_len & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    check("R12 read strobe", {31'b0, reg_rvalid}, 32'd1);
    reg_valid = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    do_read(a, d);
    check(req, d, exp);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pen = '0; m_len = '0; m_fast = '0;
  endtask

  task automatic t_reset();
    apply_reset();
    @(negedge clk);
    check("R1 irq low", {31'b0, irq_o}, 32'd0);
    check("R1 fiq low", {31'b0, fiq_o}, 32'd0);
    check("R1 rvalid idle", {31'b0, reg_rvalid}, 32'd0);
    read_check("R1 penable lo", 9'h10, 32'h0);
    read_check("R1 penable hi", 9'h14, 32'h0);
    read_check("R1 lenable", 9'h18, 32'h0);
    read_check("R1 fast ctrl", 9'h0C, 32'h0);
    @(negedge clk);
    check("R12 rvalid drops", {31'b0, reg_rvalid}, 32'd0);
  endtask

  task automatic t_enables();
    do_write(9'h10, 32'hA5A5_0F0F);
    read_check("R3 set lo", 9'h10, 32'hA5A5_0F0F);
    do_write(9'h10, 32'h0000_F000);
    read_check("R3 set keeps", 9'h10, 32'hA5A5_FF0F);
    read_check("R5 clear addr complement", 9'h1C, ~32'hA5A5_FF0F);
    do_write(9'h1C, 32'h0000_0F00);
    read_check("R4 clear lo", 9'h10, 32'hA5A5_F00F);
    do_write(9'h14, 32'h8000_0001);
    read_check("R3 set hi", 9'h14, 32'h8000_0001);
    do_write(9'h20, 32'h0000_0001);
    read_check("R4 clear hi", 9'h14, 32'h8000_0000);
    read_check("R5 clear hi complement", 9'h20, 32'h7FFF_FFFF);
    do_write(9'h18, 32'hFFFF_FF3C);
    read_check("R3 local set low byte", 9'h18, 32'h0000_003C);
    read_check("R5 local clear complement", 9'h24, 32'hFFFF_FFC3);
    do_write(9'h24, 32'hFFFF_FF0C);
    read_check("R4 local clear", 9'h18, 32'h0000_0030);
  endtask

  task automatic pend_pattern(input logic [63:0] pl, input logic [7:0] ll);
    @(negedge clk);
    periph_lvl = pl; local_lvl = ll;
    read_check("R2 pending lo", 9'h04, pl[31:0] & m_pen[31:0]);
    read_check("R2 pending hi", 9'h08, pl[63:32] & m_pen[63:32]);
    read_check("R6 summary", 9'h00, exp_summary(pl, m_pen, ll, m_len));
  endtask

  task automatic t_pending();
    logic [63:0] mir_only;
    mir_only = '0;
    for (int k = 0; k < 11; k++) mir_only[MIR[k]] = 1'b1;
    do_write(9'h10, 32'hFFFF_FFFF);
    do_write(9'h14, 32'hFFFF_FFFF);
    do_write(9'h18, 32'h0000_003C);
    pend_pattern(mir_only, 8'hA5);
    do_write(9'h1C, 32'hFFFF_FFFF);
    pend_pattern(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    do_write(9'h10, 32'h00F0_0F00);
    pend_pattern(64'h0123_4567_89AB_CDEF, 8'h5A);
    do_write(9'h1C, 32'hFFFF_FFFF);
    do_write(9'h20, 32'hFFFF_FFFF);
    do_write(9'h24, 32'h0000_00FF);
    pend_pattern(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    @(negedge clk);
    check("R7 all masked, irq low", {31'b0, irq_o}, 32'd0);
    periph_lvl = '0; local_lvl = '0;
  endtask

  task automatic t_irq();
    do_write(9'h14, 32'h0000_0100);
    do_write(9'h18, 32'h0000_0004);
    @(negedge clk);
    check("R7 idle low", {31'b0, irq_o}, 32'd0);
    periph_lvl[40] = 1'b1;
    #1 check("R12 not before edge", {31'b0, irq_o}, 32'd0);
    @(negedge clk);
    check("R7 R12 periph raises irq", {31'b0, irq_o}, 32'd1);
    periph_lvl[40] = 1'b0;
    @(negedge clk);
    check("R7 periph drop", {31'b0, irq_o}, 32'd0);
    local_lvl[3] = 1'b1;
    @(negedge clk);
    check("R7 masked local", {31'b0, irq_o}, 32'd0);
    local_lvl[2] = 1'b1;
    @(negedge clk);
    check("R7 enabled local", {31'b0, irq_o}, 32'd1);
    do_write(9'h24, 32'h0000_0004);
    check("R7 R12 clear write drops irq", {31'b0, irq_o}, 32'd0);
    local_lvl = '0;
  endtask

  task automatic t_fast();
    do_write(9'h1C, 32'hFFFF_FFFF);
    do_write(9'h20, 32'hFFFF_FFFF);
    do_write(9'h24, 32'h0000_00FF);
    do_write(9'h0C, 32'hFFFF_FF85);
    read_check("R8 fast ctrl readback", 9'h0C, 32'h0000_0085);
    @(negedge clk);
    check("R9 source idle", {31'b0, fiq_o}, 32'd0);
    periph_lvl[5] = 1'b1;
    @(negedge clk);
    check("R9 masked source drives fiq", {31'b0, fiq_o}, 32'd1);
    check("R7 masked source no irq", {31'b0, irq_o}, 32'd0);
    do_write(9'h0C, 32'h0000_0005);
    check("R9 disabled low", {31'b0, fiq_o}, 32'd0);
    do_write(9'h0C, 32'h0000_00C3);
    check("R9 local idle", {31'b0, fiq_o}, 32'd0);
    local_lvl[3] = 1'b1;
    @(negedge clk);
    check("R9 local select", {31'b0, fiq_o}, 32'd1);
    periph_lvl = '1; local_lvl = '1;
    do_write(9'h0C, 32'h0000_00C8);
    check("R10 select 72 low", {31'b0, fiq_o}, 32'd0);
    do_write(9'h0C, 32'h0000_00FF);
    check("R10 select 127 low", {31'b0, fiq_o}, 32'd0);
    do_write(9'h0C, 32'h0000_00BF);
    check("R9 select 63", {31'b0, fiq_o}, 32'd1);
    periph_lvl = '0; local_lvl = '0;
  endtask

  task automatic t_unmapped();
    do_write(9'h10, 32'h1234_5678);
    do_write(9'h18, 32'h0000_0011);
    do_write(9'h0C, 32'h0000_0042);
    read_check("R11 read 0x28", 9'h028, 32'h0);
    read_check("R11 read 0x1FC", 9'h1FC, 32'h0);
    do_write(9'h000, 32'hFFFF_FFFF);
    do_write(9'h004, 32'hFFFF_FFFF);
    do_write(9'h008, 32'hFFFF_FFFF);
    do_write(9'h028, 32'hFFFF_FFFF);
    do_write(9'h1F0, 32'hFFFF_FFFF);
    read_check("R11 penable lo kept", 9'h10, m_pen[31:0]);
    read_check("R11 penable hi kept", 9'h14, m_pen[63:32]);
    read_check("R11 lenable kept", 9'h18, {24'b0, m_len});
    read_check("R11 fast ctrl kept", 9'h0C, {24'b0, m_fast});
  endtask

  logic done = 1'b0;

  initial begin
    rst_n = 1'b0;
    periph_lvl = '0; local_lvl = '0;
    reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_pen = '0; m_len = '0; m_fast = '0;
    t_reset();
    t_enables();
    t_pending();
    t_irq();
    t_fast();
    t_unmapped();
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule